// File: doc/BRIEF.md
# Parallel-Read SAR Conversion Sequencer

This block is the digital core of a 12-bit successive-approximation converter that sits on a microprocessor-style parallel bus. A host reads it by pulling chip-select and read low together. That one access puts the last finished result on the data bus and also asks for a new conversion. The conversion then runs one bit per conversion-clock period, from the most significant bit down. An external comparator reports on each trial code, and the block keeps or drops each trial bit from that report.

The block runs on a fast system clock. It samples a slower conversion clock and the bus strobes through two-flop synchronizers. Conversions begin only on a falling edge of the conversion clock. A request must be pending before the preceding rising edge. A request that lands in the high phase, just before a falling edge, therefore skips that edge and starts on the next one. The block also drives an inverted copy of the conversion clock.

Top module: `sar_read_sequencer`

## Requirements
- R1: While `cs_n` and `rd_n` are both low, `data_oe` is 1 and `data_out` carries the stored result, with bit 11 as the most significant bit. When either strobe is high, `data_oe` is 0 and `data_out` is all zeros.
- R2: When the block is idle, a fall of the combined strobe condition (both strobes low) starts a conversion, and `busy_n` goes low.
- R3: `busy_n` stays low for exactly 12.5 conversion-clock periods. The conversion starts on a falling edge of the conversion clock and ends on the rising edge 12 periods later.
- R4: A request pending before a rising edge of the conversion clock starts on the next falling edge. A request that arrives during the high phase skips the next falling edge and starts on the one after it. With a 16-cycle period, this gives a latency of about 16 to 20 system cycles for a request made early in the low phase, and 24 to 28 for one made early in the high phase.
- R5: The trial code starts at 0x800 and resolves from the MSB down. A bit is kept when `cmp_in` is 1 (input at or above the trial) and cleared otherwise. The final result therefore equals the largest code for which the comparator held. `trial_code` is zero while idle.
- R6: The result register updates only when `busy_n` rises. A read during a conversion returns the previous result.
- R7: A strobe that arrives while `busy_n` is low is ignored. It neither alters the running conversion nor causes a later one.
- R8: After synchronous reset, `busy_n` is 1, the stored result is zero and `data_oe` is 0.
- R9: `conv_clk_out` is always the inverse of `conv_clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| conv_clk | input | 1 | Conversion clock |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| cmp_in | input | 1 | Comparator decision, 1 = input at or above trial code |
| conv_clk_out | output | 1 | Inverted conversion clock |
| busy_n | output | 1 | Low while a conversion runs |
| data_oe | output | 1 | Data bus output enable |
| data_out | output | 12 | Result bus, zero when not enabled |
| trial_code | output | 12 | Code presented to the external DAC |

## Verification
The assertions check on every cycle that a disabled bus carries zeros, that `busy_n` falls only right after a detected falling edge of the conversion clock and rises only right after a detected rising edge, that every conversion opens with the MSB trial, and that an enabled bus holds steady during a conversion. The bench's scenarios are the only evidence of the rest. These are the numeric results for several comparator thresholds, the exact 12.5-period length of a conversion, and the skipped edge for a late request, which shows up as a latency difference between the two phases. The scenarios also show that a strobe made during a conversion leaves no trace afterwards.

// File: rtl/sar_read_sequencer.sv
module sar_read_sequencer #(
  parameter int WIDTH = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             conv_clk,
  input  logic             cs_n,
  input  logic             rd_n,
  input  logic             cmp_in,
  output logic             conv_clk_out,
  output logic             busy_n,
  output logic             data_oe,
  output logic [WIDTH-1:0] data_out,
  output logic [WIDTH-1:0] trial_code
);
  localparam int IW = $clog2(WIDTH);
  localparam logic [WIDTH-1:0] MSB_ONLY = {1'b1, {(WIDTH-1){1'b0}}};

  typedef enum logic [1:0] {S_IDLE, S_CONV, S_DONE} st_t;

  st_t              state;
  logic [1:0]       cc_s, rq_s;
  logic             cc_d, rq_d;
  logic             pending, armed;
  logic [IW-1:0]    idx;
  logic [WIDTH-1:0] sar, sar_nxt, result;

  wire fall_evt = cc_d & ~cc_s[1];
  wire rise_evt = ~cc_d & cc_s[1];
  wire req_evt  = rq_s[1] & ~rq_d;

  assign conv_clk_out = ~conv_clk;
  assign data_oe      = ~cs_n & ~rd_n & ~rst;
  assign data_out     = data_oe ? result : '0;
  assign trial_code   = (state == S_CONV) ? sar : '0;

  always_comb begin
    sar_nxt = sar;
    if (!cmp_in) sar_nxt[idx] = 1'b0;
    if (idx != '0) sar_nxt[idx - 1'b1] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cc_s    <= '0;
      cc_d    <= 1'b0;
      rq_s    <= '0;
      rq_d    <= 1'b0;
      state   <= S_IDLE;
      busy_n  <= 1'b1;
      pending <= 1'b0;
      armed   <= 1'b0;
      idx     <= '0;
      sar     <= '0;
      result  <= '0;
    end else begin
      cc_s <= {cc_s[0], conv_clk};
      cc_d <= cc_s[1];
      rq_s <= {rq_s[0], ~cs_n & ~rd_n};
      rq_d <= rq_s[1];
      case (state)
        S_IDLE: begin
          if (req_evt) pending <= 1'b1;
          if (rise_evt && pending) armed <= 1'b1;
          if (fall_evt && armed) begin
            state   <= S_CONV;
            busy_n  <= 1'b0;
            sar     <= MSB_ONLY;
            idx     <= IW'(WIDTH - 1);
            pending <= 1'b0;
            armed   <= 1'b0;
          end
        end
        S_CONV: begin
          if (fall_evt) begin
            sar <= sar_nxt;
            if (idx == '0) state <= S_DONE;
            else           idx   <= idx - 1'b1;
          end
        end
        default: begin
          if (rise_evt) begin
            result <= sar;
            busy_n <= 1'b1;
            state  <= S_IDLE;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/sar_read_sequencer_chk.sv
module sar_read_sequencer_chk #(
  parameter int WIDTH = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             busy_n,
  input logic             data_oe,
  input logic [WIDTH-1:0] data_out,
  input logic [WIDTH-1:0] trial_code,
  input logic             fall_evt,
  input logic             rise_evt
);
  AST_IDLE_BUS_ZERO: assert property (@(posedge clk) disable iff (rst)
    !data_oe |-> data_out == '0); // R1
  AST_START_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_n) |-> $past(fall_evt)); // R3
  AST_END_ON_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_n) |-> $past(rise_evt)); // R3
  AST_FIRST_TRIAL_MSB: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_n) |-> trial_code == {1'b1, {(WIDTH-1){1'b0}}}); // R5
  AST_IDLE_NO_TRIAL: assert property (@(posedge clk) disable iff (rst)
    busy_n |-> trial_code == '0); // R5
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
    (!busy_n && data_oe && $past(data_oe)) |-> $stable(data_out)); // R6
  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> busy_n); // R8
endmodule

bind sar_read_sequencer sar_read_sequencer_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst(rst), .busy_n(busy_n), .data_oe(data_oe),
  .data_out(data_out), .trial_code(trial_code),
  .fall_evt(fall_evt), .rise_evt(rise_evt)
);

// File: tb/test_sar_read_sequencer.sv
`timescale 1ns/1ps
module test_sar_read_sequencer;
  logic clk = 1'b0, rst = 1'b1, conv_clk = 1'b1, cs_n = 1'b1, rd_n = 1'b1;
  logic conv_clk_out, busy_n, data_oe;
  logic [11:0] data_out, trial_code, vin = '0;
  logic [2:0] ph = '0;
  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  wire cmp_in = (trial_code <= vin);

  sar_read_sequencer i_sar_read_sequencer (
    .clk(clk), .rst(rst), .conv_clk(conv_clk), .cs_n(cs_n), .rd_n(rd_n),
    .cmp_in(cmp_in), .conv_clk_out(conv_clk_out), .busy_n(busy_n),
    .data_oe(data_oe), .data_out(data_out), .trial_code(trial_code));

  always #10 clk = ~clk;

  always @(negedge clk) begin
    ph <= ph + 3'd1;
    if (ph == 3'd7) conv_clk <= ~conv_clk;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_busy(input logic val, input string req);
    int n = 0;
    while (busy_n !== val && n < 2000) begin
      @(negedge clk);
      n++;
    end
    if (busy_n !== val) check(1'b0, req, busy_n, val);
  endtask

  task automatic read_bus(output logic [11:0] d, output logic oe);
    @(negedge clk);
    cs_n = 1'b0; rd_n = 1'b0;
    repeat (2) @(negedge clk);
    d = data_out; oe = data_oe;
    cs_n = 1'b1; rd_n = 1'b1;
  endtask

  task automatic settle();
    logic [11:0] d; logic oe;
    wait_busy(1'b0, "R2 start");
    wait_busy(1'b1, "R3 end");
  endtask

  task automatic t_reset();
    logic [11:0] d; logic oe;
    @(negedge clk);
    check(busy_n === 1'b1, "R8 busy", busy_n, 1);
    check(data_oe === 1'b0, "R8 oe", data_oe, 0);
    read_bus(d, oe);
    check(d === 12'h000, "R8 result", d, 0);
    settle();
  endtask

  task automatic t_clkout();
    for (int i = 0; i < 3; i++) begin
      repeat (5) @(negedge clk);
      check(conv_clk_out === ~conv_clk, "R9 clkout", conv_clk_out, ~conv_clk);
    end
  endtask

  task automatic t_strobes();
    @(negedge clk); cs_n = 1'b0; rd_n = 1'b1;
    repeat (3) @(negedge clk);
    check(data_oe === 1'b0 && data_out === 12'h000, "R1 cs only", data_oe, 0);
    check(busy_n === 1'b1, "R2 cs only no start", busy_n, 1);
    cs_n = 1'b1; rd_n = 1'b0;
    repeat (3) @(negedge clk);
    check(data_oe === 1'b0, "R1 rd only", data_oe, 0);
    rd_n = 1'b1;
    repeat (40) @(negedge clk);
    check(busy_n === 1'b1, "R2 rd only no start", busy_n, 1);
  endtask

  task automatic t_convert(input logic [11:0] v);
    logic [11:0] d; logic oe;
    vin = v;
    read_bus(d, oe);
    settle();
    read_bus(d, oe);
    check(oe === 1'b1, "R1 oe", oe, 1);
    check(d === v, "R5 result", d, v);
    settle();
  endtask

  task automatic t_duration();
    logic [11:0] d; logic oe;
    int n = 0;
    vin = 12'h5A5;
    read_bus(d, oe);
    wait_busy(1'b0, "R2 start");
    while (busy_n === 1'b0 && n < 1000) begin
      @(negedge clk);
      n++;
    end
    check(n == 200, "R3 busy length", n, 200);
  endtask

  task automatic t_align(input bit high_phase, input int lo, input int hi);
    int lat = 0;
    @(negedge clk);
    if (high_phase) @(posedge conv_clk); else @(negedge conv_clk);
    cs_n = 1'b0; rd_n = 1'b0;
    while (busy_n === 1'b1 && lat < 100) begin
      @(negedge clk);
      lat++;
      if (lat == 3) begin cs_n = 1'b1; rd_n = 1'b1; end
    end
    cs_n = 1'b1; rd_n = 1'b1;
    check(lat >= lo && lat <= hi, high_phase ? "R4 late request skips edge" : "R4 early request", lat, lo);
    wait_busy(1'b1, "R3 end");
  endtask

  task automatic t_busy_read();
    logic [11:0] d; logic oe;
    int n = 0;
    vin = 12'h123;
    read_bus(d, oe);
    wait_busy(1'b0, "R2 start");
    repeat (50) @(negedge clk);
    read_bus(d, oe);
    check(d === 12'h5A5, "R6 read during conversion", d, 12'h5A5);
    wait_busy(1'b1, "R3 end");
    while (busy_n === 1'b1 && n < 120) begin
      @(negedge clk);
      n++;
    end
    check(n == 120, "R7 no deferred start", n, 120);
    vin = 12'h000;
    read_bus(d, oe);
    check(d === 12'h123, "R7 result intact", d, 12'h123);
    settle();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_clkout();
    t_strobes();
    t_convert(12'hA5C);
    t_convert(12'h000);
    t_convert(12'hFFF);
    t_convert(12'h800);
    t_convert(12'h001);
    t_duration();
    t_align(1'b0, 16, 20);
    t_align(1'b1, 24, 28);
    t_busy_read();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule